// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a TLB miss. It takes a 32-bit virtual address and an access kind, and it walks a two-level page table held in memory. The top ten address bits pick an entry in the outer table, which sits at the address held in the translation base register. That entry names the page that holds an inner table. The next ten bits pick the final entry in that inner table. The low twelve bits are the page offset, and the walker does not use them.

Each table read goes out on a simple memory port. The port issues a one-cycle request and accepts a one-cycle response after any delay. The walker checks every entry it reads for presence and for permission. It ends with one of two results:
- a one-cycle completion pulse that carries the frame number and the permission field, ready for a TLB fill;
- a one-cycle fault pulse that carries a fault code.

The translation base register is reloaded at a context switch through a load strobe. Each walk uses the base value that was in the register when the walk was accepted.

Top module: `ptw_walker`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `busy_o`, `done_o`, `fault_o` and `mem_req_o` are all low.
- R2: The first read of a walk goes to `B + 4*VA[31:22]`. Here B is the captured translation base with bits 11:0 forced to zero.
- R3: If the outer entry is present and permitted, the second read goes to `{E[31:12], 12'h000} + 4*VA[21:12]`. Here E is the outer entry.
- R4: Bit 0 of an entry is its present bit. If the outer entry has bit 0 clear, the walk ends with `fault_o` and code 1. No second read is made, and `busy_o` is already low in the fault cycle.
- R5: If the inner entry has bit 0 clear, the walk ends with `fault_o` and code 2.
- R6: Entry bits 2:1 set the permission: 0 read-only, 1 read-write, 2 execute-only, 3 full access. The access kind is 0 read, 1 write, 2 execute, and 3 is never permitted. A denied access at either level ends the walk with `fault_o` and code 3. Presence is tested before permission.
- R7: A walk that succeeds raises `done_o` for exactly one cycle, with `frame_o` equal to bits 31:12 and `prot_o` equal to bits 2:1 of the inner entry. Every result pulse, `done_o` or `fault_o`, lasts one cycle. The two are never high together.
- R8: Count from the acceptance edge, with w extra response cycles per read. A result at the outer level appears 2+w cycles later. A result at the inner level appears 4+2w cycles later.
- R9: `busy_o` is high from the cycle after acceptance through the `done_o` cycle. While it is high, `req_valid_i` is ignored: no further read and no further result follow from it.
- R10: `ctx_load_i` loads the base register from `ctx_base_i`. A load during a walk does not change that walk's addresses, and later walks use the new base.
- R11: Each read is a `mem_req_o` pulse exactly one cycle long, with a word-aligned `mem_addr_o`. There is one read per table level visited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_load_i | input | 1 | Load strobe for the translation base register |
| ctx_base_i | input | 32 | New translation base (bits 11:0 ignored) |
| req_valid_i | input | 1 | Walk request, taken only when idle |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | One-cycle table read request |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Entry returned by memory |
| done_o | output | 1 | One-cycle successful translation pulse |
| frame_o | output | 20 | Frame number for the TLB fill |
| prot_o | output | 2 | Permission field of the final entry |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_code_o | output | 2 | 1 outer missing, 2 inner missing, 3 permission denied |

## Verification
A result is due 2+w cycles after acceptance when it comes from the outer entry, and 4+2w cycles after acceptance when it comes from the inner entry. Here w is the extra wait the memory model inserts before each response. The driver records the cycle of acceptance and stores, in each expected item, the latency that matches the item's fault level. The monitor subtracts the two cycle numbers when the pulse appears and compares the difference. The memory model compares every read address against a separately queued list of expected addresses, so an extra read, a missing read or a misplaced read is reported.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ_OUT,
    S_WAIT_OUT,
    S_READ_IN,
    S_WAIT_IN,
    S_DONE
  } walk_state_t;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] PERM_RO   = 2'd0;
  localparam logic [1:0] PERM_RW   = 2'd1;
  localparam logic [1:0] PERM_XO   = 2'd2;
  localparam logic [1:0] PERM_FULL = 2'd3;

  localparam logic [1:0] FLT_OUTER_MISSING = 2'd1;
  localparam logic [1:0] FLT_INNER_MISSING = 2'd2;
  localparam logic [1:0] FLT_PERMISSION    = 2'd3;

  localparam int PTE_PRESENT_BIT = 0;
  localparam int PTE_PERM_LSB    = 1;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] table_base,
  input  logic [IDX_W-1:0]  index,
  output logic [ADDR_W-1:0] entry_addr
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset     = ADDR_W'(index) << ENTRY_SHIFT;
    entry_addr = table_base + offset;
  end
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       acc,
  output logic             present,
  output logic             allowed
);
  logic [1:0] perm;

  always_comb begin
    present = pte[PTE_PRESENT_BIT];
    perm    = pte[PTE_PERM_LSB +: 2];
    unique case (perm)
      PERM_RO:   allowed = (acc == ACC_READ);
      PERM_RW:   allowed = (acc == ACC_READ) || (acc == ACC_WRITE);
      PERM_XO:   allowed = (acc == ACC_EXEC);
      default:   allowed = (acc != 2'd3);
    endcase
  end

  always_comb begin
    // R6
    perm_full_chk: assert (!(present && perm == PERM_FULL && acc == 2'd3 && allowed));
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int OUT_W    = 10,
  parameter int IN_W     = 10,
  parameter int PG_OFF_W = 12,
  parameter int PTE_W    = 32,
  parameter int PA_W     = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ctx_load_i,
  input  logic [PA_W-1:0]           ctx_base_i,
  input  logic                      req_valid_i,
  input  logic [VA_W-1:0]           req_vaddr_i,
  input  logic [1:0]                req_acc_i,
  output logic                      busy_o,
  output logic                      mem_req_o,
  output logic [PA_W-1:0]           mem_addr_o,
  input  logic                      mem_rvalid_i,
  input  logic [PTE_W-1:0]          mem_rdata_i,
  output logic                      done_o,
  output logic [PTE_W-PG_OFF_W-1:0] frame_o,
  output logic [1:0]                prot_o,
  output logic                      fault_o,
  output logic [1:0]                fault_code_o
);
  localparam int FRAME_W     = PTE_W - PG_OFF_W;
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);
  localparam int VPN_W       = VA_W - PG_OFF_W;
  localparam int IDX_MAX     = (OUT_W > IN_W) ? OUT_W : IN_W;
  localparam int LEVELS      = 2;

  walk_state_t            state_q;
  logic [PA_W-1:0]        ptbr_q;
  logic [PA_W-1:0]        walk_base_q;
  logic [PA_W-1:0]        inner_base_q;
  logic [VPN_W-1:0]       vpn_q;
  logic [1:0]             acc_q;
  logic                   mem_req_q;
  logic [PA_W-1:0]        mem_addr_q;
  logic                   done_q;
  logic                   fault_q;
  logic [1:0]             code_q;
  logic [FRAME_W-1:0]     frame_q;
  logic [1:0]             prot_q;

  logic [IDX_MAX-1:0]     lvl_idx  [LEVELS];
  logic [PA_W-1:0]        lvl_tbl  [LEVELS];
  logic [PA_W-1:0]        lvl_addr [LEVELS];
  logic                   ent_present;
  logic                   ent_allowed;
  logic [PA_W-1:0]        next_inner_base;
  logic                   unused_bits;

  assign lvl_idx[0] = IDX_MAX'(vpn_q[VPN_W-1 -: OUT_W]);
  assign lvl_idx[1] = IDX_MAX'(vpn_q[IN_W-1:0]);
  assign lvl_tbl[0] = walk_base_q;
  assign lvl_tbl[1] = inner_base_q;

  for (genvar g = 0; g < LEVELS; g++) begin : g_level
    ptw_addr_gen #(
      .ADDR_W      (PA_W),
      .IDX_W       (IDX_MAX),
      .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_addr (
      .table_base (lvl_tbl[g]),
      .index      (lvl_idx[g]),
      .entry_addr (lvl_addr[g])
    );
  end

  ptw_pte_check #(.PTE_W(PTE_W)) u_check (
    .pte     (mem_rdata_i),
    .acc     (acc_q),
    .present (ent_present),
    .allowed (ent_allowed)
  );

  assign next_inner_base = PA_W'({mem_rdata_i[PTE_W-1:PG_OFF_W], {PG_OFF_W{1'b0}}});
  assign unused_bits     = ^{ctx_base_i[PG_OFF_W-1:0], req_vaddr_i[PG_OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      ptbr_q       <= '0;
      walk_base_q  <= '0;
      inner_base_q <= '0;
      vpn_q        <= '0;
      acc_q        <= '0;
      mem_req_q    <= 1'b0;
      mem_addr_q   <= '0;
      done_q       <= 1'b0;
      fault_q      <= 1'b0;
      code_q       <= '0;
      frame_q      <= '0;
      prot_q       <= '0;
    end else begin
      mem_req_q <= 1'b0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      if (ctx_load_i)
        ptbr_q <= {ctx_base_i[PA_W-1:PG_OFF_W], {PG_OFF_W{1'b0}}};
      unique case (state_q)
        S_IDLE: begin
          if (req_valid_i) begin
            vpn_q       <= req_vaddr_i[VA_W-1:PG_OFF_W];
            acc_q       <= req_acc_i;
            walk_base_q <= ptbr_q;
            state_q     <= S_READ_OUT;
          end
        end
        S_READ_OUT: begin
          mem_req_q  <= 1'b1;
          mem_addr_q <= lvl_addr[0];
          state_q    <= S_WAIT_OUT;
        end
        S_WAIT_OUT: begin
          if (mem_rvalid_i) begin
            if (!ent_present) begin
              fault_q <= 1'b1;
              code_q  <= FLT_OUTER_MISSING;
              state_q <= S_IDLE;
            end else if (!ent_allowed) begin
              fault_q <= 1'b1;
              code_q  <= FLT_PERMISSION;
              state_q <= S_IDLE;
            end else begin
              inner_base_q <= next_inner_base;
              state_q      <= S_READ_IN;
            end
          end
        end
        S_READ_IN: begin
          mem_req_q  <= 1'b1;
          mem_addr_q <= lvl_addr[1];
          state_q    <= S_WAIT_IN;
        end
        S_WAIT_IN: begin
          if (mem_rvalid_i) begin
            if (!ent_present) begin
              fault_q <= 1'b1;
              code_q  <= FLT_INNER_MISSING;
              state_q <= S_IDLE;
            end else if (!ent_allowed) begin
              fault_q <= 1'b1;
              code_q  <= FLT_PERMISSION;
              state_q <= S_IDLE;
            end else begin
              done_q  <= 1'b1;
              frame_q <= mem_rdata_i[PTE_W-1:PG_OFF_W];
              prot_q  <= mem_rdata_i[PTE_PERM_LSB +: 2];
              state_q <= S_DONE;
            end
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign mem_req_o    = mem_req_q;
  assign mem_addr_o   = mem_addr_q;
  assign done_o       = done_q;
  assign frame_o      = frame_q;
  assign prot_o       = prot_q;
  assign fault_o      = fault_q;
  assign fault_code_o = code_q;

  // R11
  mreq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o);

  // R11
  mreq_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_addr_o[ENTRY_SHIFT-1:0] == '0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!done_o && !busy_o));

  // R7
  result_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fault_o));

  // R4
  fault_idle_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!busy_o && fault_code_o != 2'd0));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(req_valid_i));

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_o);
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctx_load_i = 1'b0;
  logic [31:0] ctx_base_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        busy_o, mem_req_o, done_o, fault_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [19:0] frame_o;
  logic [1:0]  prot_o, fault_code_o;

  ptw_walker u0 (.*);

  always #5 clk = ~clk;

  typedef struct {
    bit         flt;
    logic [1:0] code;
    logic [19:0] frame;
    logic [1:0] prot;
    int         start;
    int         lat;
    string      tag;
  } exp_t;

  typedef struct {
    logic [31:0] addr;
    string       tag;
  } rd_t;

  exp_t        sb[$];
  rd_t         aq[$];
  logic [31:0] mem [int unsigned];
  int          cyc = 0;
  int          n_tests = 0;
  int          n_fail = 0;
  int          wait_n = 0;
  logic [31:0] ptbr_model = '0;
  bit          finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [31:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 32'h0;
  endfunction

  function automatic bit perm_ok(logic [1:0] p, logic [1:0] acc);
    if (acc == 2'd3) return 0;
    case (p)
      2'd0: return acc == 2'd0;
      2'd1: return acc != 2'd2;
      2'd2: return acc == 2'd2;
      default: return 1;
    endcase
  endfunction

  // memory model: checks each read address, then answers after wait_n cycles
  initial forever begin
    @(negedge clk);
    if (mem_req_o) begin
      logic [31:0] a;
      a = mem_addr_o;
      if (aq.size() == 0) chk(0, "R11", "unexpected read", a, 32'h0);
      else begin
        rd_t e;
        e = aq.pop_front();
        chk(a == e.addr, e.tag, "entry address", a, e.addr);
      end
      repeat (wait_n) @(negedge clk);
      mem_rvalid_i = 1'b1;
      mem_rdata_i  = rd(a);
      @(negedge clk);
      mem_rvalid_i = 1'b0;
      mem_rdata_i  = '0;
    end
  end

  // monitor: pops expected items as results appear
  initial forever begin
    @(negedge clk);
    if (done_o || fault_o) begin
      if (sb.size() == 0) chk(0, "R9", "unexpected result", {30'd0, done_o, fault_o}, 32'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(fault_o == e.flt, e.tag, "result kind", {31'd0, fault_o}, {31'd0, e.flt});
        if (e.flt) begin
          chk(fault_code_o == e.code, e.tag, "fault code", {30'd0, fault_code_o}, {30'd0, e.code});
          chk(!busy_o, "R4", "busy in fault cycle", {31'd0, busy_o}, 32'd0);
        end else begin
          chk(frame_o == e.frame, "R7", "frame", {12'd0, frame_o}, {12'd0, e.frame});
          chk(prot_o == e.prot, "R7", "prot", {30'd0, prot_o}, {30'd0, e.prot});
          chk(busy_o, "R9", "busy in done cycle", {31'd0, busy_o}, 32'd1);
        end
        chk(cyc - e.start == e.lat, "R8", "latency", cyc - e.start, e.lat);
      end
      @(negedge clk);
      chk(!done_o && !fault_o, "R7", "pulse width", {30'd0, done_o, fault_o}, 32'd0);
    end
  end

  task automatic load_base(logic [31:0] b);
    @(negedge clk);
    ctx_load_i = 1'b1;
    ctx_base_i = b;
    @(negedge clk);
    ctx_load_i = 1'b0;
    ptbr_model = {b[31:12], 12'h000};
  endtask

  task automatic walk(logic [31:0] va, logic [1:0] acc, string tag,
                      bit poke = 0, bit reload = 0, logic [31:0] nb = 0);
    exp_t e;
    logic [31:0] oa, ia, po, pi;
    e.tag = tag; e.flt = 0; e.code = 0; e.frame = 0; e.prot = 0;
    oa = ptbr_model + {20'd0, va[31:22], 2'b00};
    aq.push_back('{oa, "R2"});
    po = rd(oa);
    if (!po[0]) begin
      e.flt = 1; e.code = 2'd1; e.lat = 2 + wait_n;
    end else if (!perm_ok(po[2:1], acc)) begin
      e.flt = 1; e.code = 2'd3; e.lat = 2 + wait_n;
    end else begin
      ia = {po[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
      aq.push_back('{ia, "R3"});
      pi = rd(ia);
      e.lat = 4 + 2 * wait_n;
      if (!pi[0]) begin
        e.flt = 1; e.code = 2'd2;
      end else if (!perm_ok(pi[2:1], acc)) begin
        e.flt = 1; e.code = 2'd3;
      end else begin
        e.frame = pi[31:12]; e.prot = pi[2:1];
      end
    end
    @(negedge clk);
    while (busy_o) @(negedge clk);
    req_valid_i = 1'b1;
    req_vaddr_i = va;
    req_acc_i   = acc;
    @(negedge clk);
    req_valid_i = 1'b0;
    e.start = cyc;
    sb.push_back(e);
    if (poke) begin
      req_valid_i = 1'b1;
      req_vaddr_i = 32'h0140_0000;
      req_acc_i   = 2'd0;
      repeat (2) @(negedge clk);
      req_valid_i = 1'b0;
    end
    if (reload) begin
      ctx_load_i = 1'b1;
      ctx_base_i = nb;
      @(negedge clk);
      ctx_load_i = 1'b0;
      ptbr_model = {nb[31:12], 12'h000};
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    // table contents: entry = {frame[31:12], ..., perm[2:1], present[0]}
    mem[32'h0001_0004] = 32'h0002_0007;  // outer idx 1: full
    mem[32'h0002_0008] = 32'h00AB_C01B;  // inner idx 2: RW, ref+dirty
    mem[32'h0002_0010] = 32'h1234_5005;  // inner idx 4: XO
    mem[32'h0002_0024] = 32'h7FFF_F007;  // inner idx 9: full
    mem[32'h0001_000C] = 32'h0003_0001;  // outer idx 3: RO
    mem[32'h0003_0000] = 32'h0000_0003;  // inner idx 0: RW
    mem[32'h0001_0FFC] = 32'h0004_0007;  // outer idx 1023
    mem[32'h0004_0FFC] = 32'hFFFF_F003;  // inner idx 1023: RW
    mem[32'h0001_0000] = 32'h0005_0007;  // outer idx 0
    mem[32'h0005_0000] = 32'h0000_1001;  // inner idx 0: RO
    mem[32'h0006_0004] = 32'h0007_0007;  // second context, outer idx 1
    mem[32'h0007_0008] = 32'h00DE_F003;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !fault_o && !mem_req_o, "R1", "during reset",
        {28'd0, busy_o, done_o, fault_o, mem_req_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !fault_o && !mem_req_o, "R1", "after reset",
        {28'd0, busy_o, done_o, fault_o, mem_req_o}, 32'd0);

    load_base(32'h0001_0ABC);  // R10 low bits dropped

    walk(32'h0040_2345, 2'd0, "R7");   // read through RW
    walk(32'h0040_2000, 2'd1, "R7");   // write through RW
    walk(32'h0040_2FFF, 2'd2, "R6");   // exec denied at inner
    walk(32'h0140_0000, 2'd0, "R4");   // outer missing
    walk(32'h0040_7000, 2'd0, "R5");   // inner missing
    walk(32'h00C0_0000, 2'd1, "R6");   // outer RO denies write
    walk(32'h00C0_0000, 2'd0, "R7");   // outer RO allows read
    walk(32'h0040_4000, 2'd2, "R7");   // XO exec
    walk(32'h0040_4000, 2'd0, "R6");   // XO read denied
    walk(32'h0040_9000, 2'd3, "R6");   // reserved access kind
    walk(32'h0040_9000, 2'd2, "R7");   // full access exec
    walk(32'hFFFF_F123, 2'd0, "R2");   // top indices
    walk(32'h0000_0000, 2'd0, "R2");   // zero indices

    wait_n = 3;
    walk(32'h0040_2345, 2'd0, "R8");
    walk(32'h0140_0000, 2'd0, "R8");
    walk(32'h0040_2345, 2'd1, "R9", 1'b1);  // requests while busy ignored
    chk(aq.size() == 0, "R9", "pending reads after poke", aq.size(), 32'd0);
    walk(32'h0040_2345, 2'd0, "R10", 1'b0, 1'b1, 32'h0006_0FFF);
    wait_n = 1;
    walk(32'h0040_2345, 2'd0, "R10");  // new base in effect
    chk(aq.size() == 0, "R11", "unread expected addresses", aq.size(), 32'd0);

    summary();
    $finish;
  end
endmodule